// File: doc/BRIEF.md
# Multichannel High/Low Count PWM Controller

This block drives a set of independent pulse-width-modulated outputs, six by default. Software configures it through a small memory-mapped 32-bit register space. Each channel has two registers. The control word carries the run bit. The timing word states how many input-clock cycles the output stays high and how many it then stays low. The waveform therefore has a period of high plus low cycles and a duty of high over that sum. Any conversion from time units to cycle counts is done by software before the write.

A running channel adopts a newly written timing word only when its current period has finished, so a reprogramming never produces a truncated or stretched pulse. Clearing the run bit is different: it forces the output low straight away, even in the middle of a high phase. Registers are written with a single-cycle write strobe. The read data path is combinational from the address.

Top module: `multi_pwm`

## Requirements
- R1: Channel n (0 to NUM_CH-1) has its control word at byte offset 4*n and its timing word at byte offset 0x20 + 4*n. `rdata` shows the addressed register in the same cycle, with no clock edge needed, and each register is distinct from every other.
- R2: The control word holds all 32 written bits and reads them back unchanged. Bit 31 is the channel's run bit. Bits [30:0], including the lead-in field in [15:0], have no effect on the output.
- R3: The timing word's bits [31:16] give the high count and bits [15:0] give the low count, each up to 0xFFFF cycles. It reads back exactly the last value written to it; for example, 0x3A982710 means 0x3A98 high cycles and 0x2710 low cycles.
- R4: After reset, every control word and every timing word reads 0 and every output is low.
- R5: Suppose a write sets the run bit of a stopped channel at clock edge k, with high count H > 0 and low count L. The output stays low after edge k, is high for H cycles starting after edge k+1, then is low for L cycles, and this period of H+L cycles repeats.
- R6: A write that clears the run bit takes the output low directly after the same clock edge that stores it, whatever the phase. The output stays low while the bit is clear.
- R7: A timing word written while the channel runs leaves the current period untouched. The new counts govern the period that starts after the current one ends.
- R8: A high count of 0 keeps the output low. A low count of 0 with a non-zero high count keeps it high. Both counts at 0 keep it low.
- R9: Offsets outside the map read as 0, and writes to them change no register and no output. These are the offsets with bits [1:0] not zero, offsets 4*NUM_CH to 0x1F, and offsets from 0x20 + 4*NUM_CH upward.
- R10: Every channel keeps its own period when other channels' registers are written or other channels run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the unit of the high and low counts |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe; stores `wdata` at `addr` on the rising edge |
| addr | input | 8 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
A register write takes effect at the rising edge that samples the strobe. Read data follows the address with no edge at all. An enabled channel first drives high one edge after the write that set its run bit. A cleared run bit takes effect at the write edge itself. A new timing word shows only from the first cycle of the following period. The bench drives inputs and samples outputs on the falling edge. Each waveform check therefore sees the state left by exactly one known number of rising edges after the write. The expected level for that position is computed from the programmed high and low counts, and the cycle of a timing change is worked out by hand from the period boundary.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    // Register geometry: fixed by the software-visible map
    localparam int unsigned REG_AW    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned CNT_W     = 16;
    localparam int unsigned RUN_BIT   = 31;
    localparam int unsigned CTRL_BASE = 'h00;
    localparam int unsigned TIME_BASE = 'h20;
    localparam int unsigned MAX_CH    = 8;

    // Timing word: high count in the upper half, low count in the lower half
    typedef struct packed {
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] lo_cnt;
    } timing_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_TIME = 2'd2
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e   kind;
        logic [2:0]  idx;
    } reg_sel_t;

    // Decode a byte offset into register kind and channel index
    function automatic reg_sel_t decode_addr(input logic [REG_AW-1:0] a,
                                             input int unsigned num_ch);
        reg_sel_t sel;
        sel.kind = SEL_NONE;
        sel.idx  = '0;
        if (a[1:0] == 2'b00) begin
            for (int n = 0; n < int'(MAX_CH); n++) begin
                if (n < int'(num_ch)) begin
                    if (a == REG_AW'(CTRL_BASE + 4 * n)) begin
                        sel.kind = SEL_CTRL;
                        sel.idx  = 3'(n);
                    end
                    if (a == REG_AW'(TIME_BASE + 4 * n)) begin
                        sel.kind = SEL_TIME;
                        sel.idx  = 3'(n);
                    end
                end
            end
        end
        return sel;
    endfunction

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int unsigned NUM_CH = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [REG_AW-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_CH-1:0]          run_vec,
    output timing_t [NUM_CH-1:0]       timing_vec
);

    logic [DATA_W-1:0] ctrl_q [NUM_CH];
    timing_t           time_q [NUM_CH];
    reg_sel_t          sel;

    assign sel = decode_addr(addr, NUM_CH);

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_reg
        logic hit_ctrl;
        logic hit_time;

        assign hit_ctrl = wr_en && (sel.kind == SEL_CTRL) && (sel.idx == 3'(i));
        assign hit_time = wr_en && (sel.kind == SEL_TIME) && (sel.idx == 3'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[i] <= '0;
                time_q[i] <= '0;
            end else begin
                if (hit_ctrl) ctrl_q[i] <= wdata;
                if (hit_time) time_q[i] <= timing_t'(wdata);
            end
        end

        assign run_vec[i]    = ctrl_q[i][RUN_BIT];
        assign timing_vec[i] = time_q[i];
    end

    // Combinational read path; unmapped offsets return zero
    always_comb begin
        rdata = '0;
        for (int n = 0; n < int'(NUM_CH); n++) begin
            if (sel.idx == 3'(n)) begin
                unique case (sel.kind)
                    SEL_CTRL: rdata = ctrl_q[n];
                    SEL_TIME: rdata = DATA_W'(time_q[n]);
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
    import pwmx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  timing_t cfg,
    output logic    wave,
    output logic    active,
    output logic    wrap
);

    localparam int unsigned POS_W = CNT_W + 1;
    localparam int unsigned CMP_W = POS_W + 1;

    logic             running_q;
    logic [POS_W-1:0] pos_q;
    timing_t          cur_q;

    logic [POS_W-1:0] total;
    logic             last;

    // Period length in cycles and end-of-period detect (total of 0 wraps every cycle)
    assign total = POS_W'(cur_q.hi_cnt) + POS_W'(cur_q.lo_cnt);
    assign last  = (CMP_W'(pos_q) + CMP_W'(1)) >= CMP_W'(total);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            running_q <= 1'b0;
            pos_q     <= '0;
            cur_q     <= '0;
        end else if (!running_q) begin
            running_q <= 1'b1;
            pos_q     <= '0;
            cur_q     <= cfg;
        end else if (last) begin
            pos_q     <= '0;
            cur_q     <= cfg;
        end else begin
            pos_q     <= pos_q + POS_W'(1);
        end
    end

    // Enable gates the output directly so a stop needs no extra edge
    assign wave   = enable && running_q && (pos_q < POS_W'(cur_q.hi_cnt));
    assign active = running_q;
    assign wrap   = running_q && last;

endmodule

// File: rtl/multi_pwm.sv
module multi_pwm
    import pwmx_pkg::*;
#(
    parameter int unsigned NUM_CH = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic [NUM_CH-1:0]   pwm_out
);

    logic [NUM_CH-1:0]    en_vec;
    logic [NUM_CH-1:0]    act_vec;
    logic [NUM_CH-1:0]    wrap_vec;
    timing_t [NUM_CH-1:0] timing_vec;

    pwmx_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .run_vec    (en_vec),
        .timing_vec (timing_vec)
    );

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
        pwmx_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .enable (en_vec[i]),
            .cfg    (timing_vec[i]),
            .wave   (pwm_out[i]),
            .active (act_vec[i]),
            .wrap   (wrap_vec[i])
        );
    end

endmodule

// File: rtl/pwmx_chk.sv
module pwmx_chk #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] act_vec,
    input logic [NUM_CH-1:0] wrap_vec
);

    logic mapped;
    assign mapped = (addr[1:0] == 2'b00) &&
                    ((addr < 8'(4 * NUM_CH)) ||
                     ((addr >= 8'h20) && (addr < 8'(32 + 4 * NUM_CH))));

    // R4
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_vec == '0 && pwm_out == '0));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (rdata == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped) |=> $stable(en_vec));

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
        // R6
        stop_now_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == 8'(4 * i) && !wdata[31]) |=> !pwm_out[i]);

        // R7
        rise_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_out[i]) |-> ($past(wrap_vec[i]) || !$past(act_vec[i])));
    end

endmodule

bind multi_pwm pwmx_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pwm_out  (pwm_out),
    .en_vec   (en_vec),
    .act_vec  (act_vec),
    .wrap_vec (wrap_vec)
);

// File: tb/tb_multi_pwm.sv
`timescale 1ns/1ps
module tb_multi_pwm;

    localparam int NCH = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [7:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    multi_pwm #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic exp_wave(input int hi, input int lo, input int j);
        if (hi == 0) return 1'b0;
        if (lo == 0) return 1'b1;
        return (j % (hi + lo)) < hi;
    endfunction

    function automatic logic [7:0] ctrl_a(input int ch);
        return 8'(4 * ch);
    endfunction

    function automatic logic [7:0] time_a(input int ch);
        return 8'(32 + 4 * ch);
    endfunction

    task automatic run_check(input string tag, input int ch, input int hi, input int lo,
                             input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            chk(tag, 32'(pwm_out[ch]), 32'(exp_wave(hi, lo, j)));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R4 outputs low after reset", 32'(pwm_out), 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rd(ctrl_a(c), d); chk("R4 control word zero", d, 32'h0);
            rd(time_a(c), d); chk("R4 timing word zero", d, 32'h0);
        end
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        @(negedge clk);
        wr(ctrl_a(5), 32'h7FFF_ABCD);
        rd(ctrl_a(5), d); chk("R2 control readback", d, 32'h7FFF_ABCD);
        wr(time_a(2), 32'h3A98_2710);
        rd(time_a(2), d); chk("R3 timing readback", d, 32'h3A98_2710);
        rd(ctrl_a(2), d); chk("R1 control of ch2 separate", d, 32'h0);
        rd(time_a(5), d); chk("R1 timing of ch5 separate", d, 32'h0);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            chk("R2 low bits do not run ch5", 32'(pwm_out[5]), 32'h0);
        end
        wr(ctrl_a(5), 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R9 read of 0x18", d, 32'h0);
        wr(8'h22, 32'h1234_5678);
        rd(time_a(0), d); chk("R9 misaligned write ignored", d, 32'h0);
        wr(8'h3C, 32'h8000_0000);
        rd(8'h3C, d); chk("R9 read of 0x3C", d, 32'h0);
        rd(ctrl_a(0), d); chk("R9 no control changed", d, 32'h0);
        @(negedge clk);
        chk("R9 outputs stay low", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_basic();
        wr(time_a(0), 32'h0003_0002);
        wr(ctrl_a(0), 32'h8000_0000);
        chk("R5 low right after enable edge", 32'(pwm_out[0]), 32'h0);
        run_check("R5 waveform 3 high 2 low", 0, 3, 2, 12);
        wr(ctrl_a(0), 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        wr(time_a(2), 32'h000A_0005);
        wr(ctrl_a(2), 32'h8000_0000);
        run_check("R6 high before stop", 2, 10, 5, 3);
        wr(ctrl_a(2), 32'h0000_0011);
        chk("R6 low at the stop edge", 32'(pwm_out[2]), 32'h0);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R6 stays low", 32'(pwm_out[2]), 32'h0);
        end
        rd(ctrl_a(2), d); chk("R6 control reads back", d, 32'h0000_0011);
    endtask

    task automatic t_shadow();
        wr(time_a(1), 32'h0003_0002);
        wr(ctrl_a(1), 32'h8000_0000);
        run_check("R7 first cycles", 1, 3, 2, 2);
        wr(time_a(1), 32'h0001_0004);
        chk("R7 current high phase kept", 32'(pwm_out[1]), 32'h1);
        for (int j = 3; j < 16; j++) begin
            logic e;
            @(negedge clk);
            e = (j < 5) ? (j < 3) : exp_wave(1, 4, j - 5);
            chk("R7 new counts from next period", 32'(pwm_out[1]), 32'(e));
        end
        wr(ctrl_a(1), 32'h0);
    endtask

    task automatic t_zero();
        wr(time_a(0), 32'h0000_0005);
        wr(ctrl_a(0), 32'h8000_0000);
        run_check("R8 high count zero", 0, 0, 5, 8);
        wr(ctrl_a(0), 32'h0);
        wr(time_a(0), 32'h0004_0000);
        wr(ctrl_a(0), 32'h8000_0000);
        run_check("R8 low count zero", 0, 4, 0, 8);
        wr(ctrl_a(0), 32'h0);
        wr(time_a(0), 32'h0000_0000);
        wr(ctrl_a(0), 32'h8000_0000);
        run_check("R8 both counts zero", 0, 0, 0, 6);
        wr(ctrl_a(0), 32'h0);
    endtask

    task automatic t_indep();
        wr(time_a(3), 32'h0002_0002);
        wr(time_a(4), 32'h0001_0003);
        wr(ctrl_a(3), 32'h8000_0000);
        wr(ctrl_a(4), 32'h8000_0000);
        chk("R10 ch3 runs during ch4 write", 32'(pwm_out[3]), 32'(exp_wave(2, 2, 0)));
        chk("R10 ch4 not yet high", 32'(pwm_out[4]), 32'h0);
        for (int m = 1; m < 13; m++) begin
            @(negedge clk);
            chk("R10 ch3 period", 32'(pwm_out[3]), 32'(exp_wave(2, 2, m)));
            chk("R10 ch4 period", 32'(pwm_out[4]), 32'(exp_wave(1, 3, m - 1)));
        end
        wr(ctrl_a(3), 32'h0);
        wr(ctrl_a(4), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_unmapped();
        t_basic();
        t_stop();
        t_shadow();
        t_zero();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule